// File: doc/BRIEF.md
# Zero-Operand Multiplier Shutoff Grid

This block is the gating control for a square output-stationary multiply-accumulate grid. Each cycle it takes one operand per row at the left edge and one per column at the top, both as unskewed vectors. It staggers them internally so that row i lags by i cycles and column j lags by j cycles. The operands then ripple right and down through the grid, and each travels with a one-bit zero flag that is computed once at the edge.

Wherever the row flag or the column flag present at an element is set, that element's multiplier is shut off. A retention register models the off state by holding the last product. An isolation clamp feeds zero to the accumulator, so a shut-off element leaves its sum untouched. When the element wakes, it captures a fresh product on the next edge and adds only that product. The block also reports a per-element shutoff map and a count of elements that are off, for power estimation.

Top module: `zero_gate_array`

## Requirements
- R1: Synchronous active-high reset sets every element to the off state (map all ones, count equal to N*N), clears every held product to zero and clears every accumulator to zero.
- R2: A zero row operand presented at cycle k sets the shutoff bit of every element (i,j) in that row, in the cycle after i+j+1 edges, whatever the column operands are.
- R3: A zero column operand presented at cycle k sets the shutoff bit of every element (i,j) in that column, in the cycle after i+j+1 edges, whatever the row operands are.
- R4: When a row operand and a column operand are both zero, the elements of that whole row and of that whole column are all shut off together. The shutoff map bit for element (i,j) is at index i*N+j.
- R5: With both operands nonzero at element (i,j), the held product becomes their signed two's-complement product one edge after the pair reaches the element.
- R6: While an element is shut off, its held product keeps its previous value.
- R7: While isolation is active (the cycle after an off cycle), the element's accumulator does not change.
- R8: On wake-up the element adds the fresh product in the next cycle, and a retained product is never added.
- R9: Each accumulator holds the signed dot product of its row and column operand streams, sign-extended to the accumulator width.
- R10: The shutoff count equals the number of set bits in the shutoff map in the same cycle.
- R11: Row operand i and column operand j presented in the same cycle meet at element (i,j) after exactly i+j+1 edges, so element (i,j) pairs only same-cycle operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_ops | input | N*OP_W | Left-edge operands, row i in bits [i*OP_W +: OP_W], signed |
| col_ops | input | N*OP_W | Top-edge operands, column j in bits [j*OP_W +: OP_W], signed |
| gate_map | output | N*N | Per-element shutoff, bit i*N+j for element (i,j) |
| gate_count | output | clog2(N*N+1) | Number of elements shut off this cycle |
| held_prod | output | N*N*2*OP_W | Retention register of each element, signed |
| acc_flat | output | N*N*ACC_W | Accumulator of each element, signed |

## Verification
The bench builds the grid at N=4 with 8-bit operands and 32-bit accumulators. At that size, element (3,3) sees its operands seven edges after the edge, so every skew depth from 0 to 6 is exercised, along with every mix of row-only, column-only and crossed gating. The 8-bit width brings the extreme products (-128 times -128, and 127 times -128) within reach. The bench steps through sequences in which an element is off for one or more cycles between on cycles, and checks the map, the held products and the accumulators every cycle. A retained product that is wrongly added, or a skew that is off by one, therefore shows up as a wrong sum or a wrong map bit at a known cycle.

// File: rtl/zgate_pkg.sv
package zgate_pkg;
    localparam int unsigned DEF_OP_W  = 8;
    localparam int unsigned DEF_ACC_W = 32;

    typedef enum logic {
        PE_AWAKE  = 1'b0,
        PE_ASLEEP = 1'b1
    } pe_pwr_e;

    function automatic int unsigned flat_idx(int unsigned r, int unsigned c, int unsigned n);
        return r * n + c;
    endfunction
endpackage

// File: rtl/zgate_delay.sv
module zgate_delay #(
    parameter int unsigned W       = 9,
    parameter int unsigned DEPTH   = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < int'(DEPTH); k++) stg[k] <= RST_VAL;
        end else begin
            stg[0] <= din;
            for (int k = 1; k < int'(DEPTH); k++) stg[k] <= stg[k-1];
        end
    end

    assign dout = stg[DEPTH-1];
endmodule

// File: rtl/zgate_popcnt.sv
module zgate_popcnt #(
    parameter int unsigned NB = 16,
    parameter int unsigned CW = 5
) (
    input  logic [NB-1:0] bits,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int k = 0; k < int'(NB); k++) cnt = cnt + CW'(bits[k]);
    end
endmodule

// File: rtl/zgate_pe.sv
module zgate_pe
    import zgate_pkg::*;
#(
    parameter int unsigned OP_W  = DEF_OP_W,
    parameter int unsigned ACC_W = DEF_ACC_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [OP_W-1:0]       a,
    input  logic [OP_W-1:0]       b,
    input  logic                  off,
    output logic [2*OP_W-1:0]     prod_q,
    output logic [ACC_W-1:0]      acc_q
);
    localparam int unsigned PROD_W = 2 * OP_W;
    localparam int unsigned EXT_W  = ACC_W - PROD_W;

    logic signed [OP_W-1:0]   a_s, b_s;
    logic signed [PROD_W-1:0] fresh;
    logic [PROD_W-1:0]        iso_view;
    pe_pwr_e                  iso_q;

    assign a_s   = a;
    assign b_s   = b;
    assign fresh = a_s * b_s;

    // isolation clamp on the multiplier output seen by the adder
    assign iso_view = (iso_q == PE_ASLEEP) ? '0 : prod_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
            iso_q  <= PE_ASLEEP;
            acc_q  <= '0;
        end else begin
            if (!off) prod_q <= fresh;           // retention otherwise
            iso_q <= off ? PE_ASLEEP : PE_AWAKE;
            acc_q <= acc_q + {{EXT_W{iso_view[PROD_W-1]}}, iso_view};
        end
    end

    // R6: shut-off element keeps its held product
    p_retain_r6: assert property (@(posedge clk) disable iff (rst)
        off |=> $stable(prod_q));

    // R7: isolated element leaves its accumulator alone
    p_iso_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (iso_q == PE_ASLEEP) |=> $stable(acc_q));

    // R8: waking element captures the fresh product and drops isolation together
    p_wake_fresh_r8: assert property (@(posedge clk) disable iff (rst)
        (iso_q == PE_ASLEEP && !off) |=> (iso_q == PE_AWAKE && prod_q == $past(fresh)));
endmodule

// File: rtl/zero_gate_array.sv
module zero_gate_array
    import zgate_pkg::*;
#(
    parameter int unsigned N     = 4,
    parameter int unsigned OP_W  = DEF_OP_W,
    parameter int unsigned ACC_W = DEF_ACC_W,
    localparam int unsigned CNT_W  = $clog2(N*N+1),
    localparam int unsigned PROD_W = 2 * OP_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N*OP_W-1:0]       row_ops,
    input  logic [N*OP_W-1:0]       col_ops,
    output logic [N*N-1:0]          gate_map,
    output logic [CNT_W-1:0]        gate_count,
    output logic [N*N*PROD_W-1:0]   held_prod,
    output logic [N*N*ACC_W-1:0]    acc_flat
);
    localparam int unsigned LW = OP_W + 1;           // {zero flag, operand}
    localparam logic [LW-1:0] LANE_IDLE = {1'b1, {OP_W{1'b0}}};

    logic [LW-1:0] row_lane [N];
    logic [LW-1:0] col_lane [N];
    logic [LW-1:0] row_edge [N];
    logic [LW-1:0] col_edge [N];
    logic [LW-1:0] rpipe [N][N];
    logic [LW-1:0] cpipe [N][N];

    // edge flag generation and input skew
    for (genvar e = 0; e < N; e++) begin : g_edge
        assign row_lane[e] = {(row_ops[e*OP_W +: OP_W] == '0), row_ops[e*OP_W +: OP_W]};
        assign col_lane[e] = {(col_ops[e*OP_W +: OP_W] == '0), col_ops[e*OP_W +: OP_W]};
        if (e == 0) begin : g_noskew
            assign row_edge[e] = row_lane[e];
            assign col_edge[e] = col_lane[e];
        end else begin : g_skew
            zgate_delay #(.W(LW), .DEPTH(e), .RST_VAL(LANE_IDLE)) u_rskew (
                .clk(clk), .rst(rst), .din(row_lane[e]), .dout(row_edge[e]));
            zgate_delay #(.W(LW), .DEPTH(e), .RST_VAL(LANE_IDLE)) u_cskew (
                .clk(clk), .rst(rst), .din(col_lane[e]), .dout(col_edge[e]));
        end
    end

    // systolic transport: rows move right, columns move down
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(N); i++)
                for (int j = 0; j < int'(N); j++) begin
                    rpipe[i][j] <= LANE_IDLE;
                    cpipe[i][j] <= LANE_IDLE;
                end
        end else begin
            for (int i = 0; i < int'(N); i++)
                for (int j = 0; j < int'(N); j++) begin
                    rpipe[i][j] <= (j == 0) ? row_edge[i] : rpipe[i][(j == 0) ? 0 : j-1];
                    cpipe[i][j] <= (i == 0) ? col_edge[j] : cpipe[(i == 0) ? 0 : i-1][j];
                end
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            localparam int unsigned IDX = flat_idx(i, j, N);
            logic off;
            assign off = rpipe[i][j][OP_W] | cpipe[i][j][OP_W];
            assign gate_map[IDX] = off;

            zgate_pe #(.OP_W(OP_W), .ACC_W(ACC_W)) u_pe (
                .clk    (clk),
                .rst    (rst),
                .a      (rpipe[i][j][OP_W-1:0]),
                .b      (cpipe[i][j][OP_W-1:0]),
                .off    (off),
                .prod_q (held_prod[IDX*PROD_W +: PROD_W]),
                .acc_q  (acc_flat[IDX*ACC_W +: ACC_W])
            );

            // R2: row flag still matches the row operand after transport
            p_row_flag_r2: assert property (@(posedge clk) disable iff (rst)
                rpipe[i][j][OP_W] == (rpipe[i][j][OP_W-1:0] == '0));
            // R3: column flag still matches the column operand after transport
            p_col_flag_r3: assert property (@(posedge clk) disable iff (rst)
                cpipe[i][j][OP_W] == (cpipe[i][j][OP_W-1:0] == '0));
        end
    end

    zgate_popcnt #(.NB(N*N), .CW(CNT_W)) u_cnt (
        .bits(gate_map),
        .cnt (gate_count)
    );

    // R10: reported count agrees with the map
    p_count_r10: assert property (@(posedge clk) disable iff (rst)
        gate_count == CNT_W'($countones(gate_map)));
endmodule

// File: tb/sim_zero_gate_array.sv
module sim_zero_gate_array;
    localparam int N    = 4;
    localparam int OPW  = 8;
    localparam int ACCW = 32;
    localparam int PW   = 2 * OPW;
    localparam int CW   = $clog2(N*N+1);
    localparam int MAXT = 16;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [N*OPW-1:0]     row_ops = '0;
    logic [N*OPW-1:0]     col_ops = '0;
    logic [N*N-1:0]       gate_map;
    logic [CW-1:0]        gate_count;
    logic [N*N*PW-1:0]    held_prod;
    logic [N*N*ACCW-1:0]  acc_flat;

    int n_chk  = 0;
    int n_fail = 0;
    int av [MAXT][N];
    int bv [MAXT][N];
    int T;

    always #10 clk = ~clk;

    zero_gate_array #(.N(N), .OP_W(OPW), .ACC_W(ACCW)) u0 (
        .clk(clk), .rst(rst), .row_ops(row_ops), .col_ops(col_ops),
        .gate_map(gate_map), .gate_count(gate_count),
        .held_prod(held_prod), .acc_flat(acc_flat));

    task automatic check(string tag, string what, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    function automatic bit pair_off(int k, int i, int j);
        if (k < 0 || k >= T) return 1'b1;
        return (av[k][i] == 0) || (bv[k][j] == 0);
    endfunction

    function automatic int pair_prod(int k, int i, int j);
        if (k < 0 || k >= T) return 0;
        return av[k][i] * bv[k][j];
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        row_ops = '0;
        col_ops = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic clear_vecs();
        for (int k = 0; k < MAXT; k++)
            for (int e = 0; e < N; e++) begin
                av[k][e] = 0;
                bv[k][e] = 0;
            end
    endtask

    // With d edges done, element (i,j) holds pair d-1-i-j, product of pair d-2-i-j
    // (last on one), and the sum of pairs up to d-3-i-j.
    task automatic run_seq(string map_tag, string prod_tag, string acc_tag);
        do_reset();
        for (int d = 0; d < T + 2*N + 4; d++) begin
            int ones = 0;
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++) begin
                    int idx = i*N + j;
                    int hp  = 0;
                    int sum = 0;
                    bit eo  = pair_off(d-1-i-j, i, j);
                    ones += eo;
                    for (int k = 0; k <= d-2-i-j; k++)
                        if (!pair_off(k, i, j)) hp = pair_prod(k, i, j);
                    for (int k = 0; k <= d-3-i-j; k++) sum += pair_prod(k, i, j);
                    check(map_tag, $sformatf("map(%0d,%0d) d=%0d", i, j, d), int'(gate_map[idx]), int'(eo));
                    check(prod_tag, $sformatf("prod(%0d,%0d) d=%0d", i, j, d),
                          int'($signed(held_prod[idx*PW +: PW])), hp);
                    check(acc_tag, $sformatf("acc(%0d,%0d) d=%0d", i, j, d),
                          int'($signed(acc_flat[idx*ACCW +: ACCW])), sum);
                end
            check("R10", $sformatf("count d=%0d", d), int'(gate_count), ones);
            for (int e = 0; e < N; e++) begin
                row_ops[e*OPW +: OPW] = (d < T) ? av[d][e][OPW-1:0] : '0;
                col_ops[e*OPW +: OPW] = (d < T) ? bv[d][e][OPW-1:0] : '0;
            end
            @(negedge clk);
        end
    endtask

    // R1: reset after activity clears everything and gates the whole grid
    task automatic t_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", "count after reset", int'(gate_count), N*N);
        check("R1", "map after reset", int'(gate_map == '1), 1);
        check("R1", "held products zero", int'(held_prod == '0), 1);
        check("R1", "accumulators zero", int'(acc_flat == '0), 1);
        rst = 1'b0;
    endtask

    // R2: rows 1 and 3 zero in some cycles, columns always nonzero
    task automatic t_rows();
        clear_vecs();
        T = 8;
        for (int k = 0; k < T; k++)
            for (int e = 0; e < N; e++) begin
                av[k][e] = ((e == 1 && k < 4) || (e == 3 && k % 2 == 1)) ? 0 : (k + e + 2);
                bv[k][e] = e - 5 - k;
            end
        run_seq("R2", "R6", "R9");
    endtask

    // R3: columns 0 and 2 zero in some cycles, rows always nonzero
    task automatic t_cols();
        clear_vecs();
        T = 8;
        for (int k = 0; k < T; k++)
            for (int e = 0; e < N; e++) begin
                av[k][e] = 3 * e + k - 11;
                if (av[k][e] == 0) av[k][e] = 1;
                bv[k][e] = ((e == 0 && k > 2) || (e == 2 && k % 3 == 0)) ? 0 : (2 * k - e + 9);
            end
        run_seq("R3", "R6", "R9");
    endtask

    // R4: crossing zero row and zero column in the same cycle
    task automatic t_both();
        clear_vecs();
        T = 6;
        for (int k = 0; k < T; k++)
            for (int e = 0; e < N; e++) begin
                av[k][e] = (e == (k % N)) ? 0 : (e + 4);
                bv[k][e] = (e == ((k + 2) % N)) ? 0 : (k - 9);
            end
        run_seq("R4", "R6", "R7");
    endtask

    // R6 R7 R8: on, off, wake, on, off, wake; a retained 15 must never be re-added
    task automatic t_wake();
        clear_vecs();
        T = 6;
        for (int e = 0; e < N; e++) begin
            av[0][e] = 5;  bv[0][e] = 3;
            av[1][e] = 0;  bv[1][e] = 3;
            av[2][e] = 2;  bv[2][e] = 2;
            av[3][e] = -7; bv[3][e] = 4;
            av[4][e] = 6;  bv[4][e] = 0;
            av[5][e] = 1;  bv[5][e] = 1;
        end
        run_seq("R7", "R6", "R8");
    endtask

    // R5 R9 R11: dense signed streams with extreme products
    task automatic t_dot();
        clear_vecs();
        T = 10;
        for (int k = 0; k < T; k++)
            for (int e = 0; e < N; e++) begin
                av[k][e] = ((k * 7 + e * 3) % 13) - 6;
                bv[k][e] = ((k * 5 + e * 11) % 17) - 8;
                if (av[k][e] == 0) av[k][e] = 9 + e;
                if (bv[k][e] == 0) bv[k][e] = -3 - e;
            end
        for (int e = 0; e < N; e++) begin
            av[0][e] = -128;
            bv[0][e] = (e % 2 == 0) ? -128 : 127;
            av[1][e] = 127;
            bv[1][e] = -128;
        end
        run_seq("R11", "R5", "R9");
    endtask

    initial begin
        t_rows();
        t_cols();
        t_both();
        t_wake();
        t_dot();
        t_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule